// File: doc/BRIEF.md
# In-Order Destination Scoreboard

This block records the destination register of every instruction that has been dispatched from decode but has not yet written back. Each dispatched instruction takes one slot, in age order. An instruction without a destination still takes a slot, marked as having no destination. Entries leave only from the oldest end, one for each commit, so retirement always stays aligned with program order.

Two source lookups run in the same cycle, one for each operand of the instruction being decoded. Each lookup compares its register index against every occupied slot and raises a hit flag when a read-after-write hazard exists. A combined stall output tells the decode stage to hold dispatch while either operand conflicts or no slot is free. The stall applies only when decode is actually asking to dispatch. Once the conflicting older instruction has committed and its slot has been released, the stall clears.

Top module: `dest_scoreboard`

## Requirements
- R1: After reset the scoreboard is empty: `empty`=1, `full`=0, and both hit flags and `stall` are 0.
- R2: A slot inserted with a valid destination index causes a hit from the cycle after the insert edge on any port whose source is valid and carries the same index.
- R3: A search port whose source-valid input is 0 never reports a hit, whatever its index.
- R4: An insert with destination-valid 0 occupies a slot and counts toward `full`, but never causes a hit on any index.
- R5: Remove releases only the oldest occupied slot; younger slots keep causing hits until they are themselves removed in insert order.
- R6: After DEPTH accepted inserts without removes, `full`=1. An insert request while full is refused (`ins_ack`=0) and leaves the contents unchanged.
- R7: A remove request while empty is ignored: the contents stay unchanged, and an insert in the same cycle is still accepted.
- R8: Search results are combinational from the contents before the next clock edge. In a cycle that removes a matching slot, the hit is still reported in that cycle and drops in the next one.
- R9: The two search ports are independent; each reports its own hit from its own source.
- R10: `stall` equals `disp_req` AND (`hit_a` OR `hit_b` OR `full`).
- R11: An insert and a remove in the same cycle on a non-empty, non-full scoreboard keep the occupancy unchanged, releasing the oldest slot and appending the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_req | input | 1 | Allocate a slot for a dispatched instruction |
| ins_dst_vld | input | 1 | The dispatched instruction has a destination register |
| ins_dst_idx | input | REG_W | Destination register index |
| ins_ack | output | 1 | The insert is accepted at this edge |
| rem_req | input | 1 | The oldest instruction commits; release its slot |
| src_a_vld | input | 1 | Operand A reads a register |
| src_a_idx | input | REG_W | Operand A register index |
| hit_a | output | 1 | Operand A has a read-after-write hazard |
| src_b_vld | input | 1 | Operand B reads a register |
| src_b_idx | input | REG_W | Operand B register index |
| hit_b | output | 1 | Operand B has a read-after-write hazard |
| disp_req | input | 1 | Decode is requesting dispatch this cycle |
| stall | output | 1 | Hold dispatch |
| full | output | 1 | No free slot |
| empty | output | 1 | No occupied slot |

## Verification
Hit flags, `stall` and `ins_ack` are combinational, so they are due in the same cycle as the source, request and dispatch inputs. Each of them reflects the contents as of the last edge. An insert or remove changes `full`, `empty` and the hit flags one edge later. The bench drives inputs on the falling edge and compares every output a short delay later, before the rising edge. It then applies the same edge to its queue model, so each comparison sees exactly the contents the design holds in that cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
   // Reduction structure used to combine per-slot matches into a hit flag.
   typedef enum logic {
      MATCH_FLAT = 1'b0,
      MATCH_TREE = 1'b1
   } match_style_e;

   // Pointer width that stays legal for a depth of one.
   function automatic int unsigned ptr_width(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl #(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = sb_pkg::ptr_width(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic             pop_req,
   output logic             push_ok,
   output logic             pop_ok,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             is_full,
   output logic             is_empty
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   logic [CNT_W-1:0] count_q;

   assign is_full  = (count_q == CNT_MAX);
   assign is_empty = (count_q == '0);
   assign push_ok  = push_req && !is_full;
   assign pop_ok   = pop_req && !is_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
      end else begin
         if (push_ok) begin
            wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
         end
         if (pop_ok) begin
            rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
         end
         case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end
endmodule

// File: rtl/sb_tag_store.sv
module sb_tag_store #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned REG_W = 5,
   localparam int unsigned PTR_W = sb_pkg::ptr_width(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [PTR_W-1:0]       wr_ptr,
   input  logic                   wr_vld,
   input  logic [REG_W-1:0]       wr_idx,
   input  logic                   rd_en,
   input  logic [PTR_W-1:0]       rd_ptr,
   output logic [DEPTH-1:0]       occ,
   output logic [DEPTH-1:0]       tag_vld,
   output logic [DEPTH*REG_W-1:0] tag_idx
);
   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      localparam logic [PTR_W-1:0] SLOT = PTR_W'(s);
      logic wr_here;
      logic rd_here;

      assign wr_here = wr_en && (wr_ptr == SLOT);
      assign rd_here = rd_en && (rd_ptr == SLOT);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            occ[s]     <= 1'b0;
            tag_vld[s] <= 1'b0;
         end else if (wr_here) begin
            occ[s]     <= 1'b1;
            tag_vld[s] <= wr_vld;
         end else if (rd_here) begin
            occ[s]     <= 1'b0;
            tag_vld[s] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_idx[s*REG_W +: REG_W] <= '0;
         end else if (wr_here) begin
            tag_idx[s*REG_W +: REG_W] <= wr_idx;
         end
      end
   end
endmodule

// File: rtl/sb_match_port.sv
module sb_match_port #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned REG_W = 5,
   parameter sb_pkg::match_style_e STYLE = sb_pkg::MATCH_FLAT,
   localparam int unsigned LVL = sb_pkg::ptr_width(DEPTH),
   localparam int unsigned LEAVES = 1 << LVL
) (
   input  logic                   src_vld,
   input  logic [REG_W-1:0]       src_idx,
   input  logic [DEPTH-1:0]       occ,
   input  logic [DEPTH-1:0]       tag_vld,
   input  logic [DEPTH*REG_W-1:0] tag_idx,
   output logic                   hit
);
   logic [DEPTH-1:0] slot_eq;

   for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
      assign slot_eq[s] = occ[s] && tag_vld[s] &&
                          (tag_idx[s*REG_W +: REG_W] == src_idx);
   end

   if (STYLE == sb_pkg::MATCH_FLAT) begin : g_flat
      assign hit = src_vld && (|slot_eq);
   end else begin : g_tree
      for (genvar l = 0; l <= LVL; l++) begin : g_lvl
         logic [(LEAVES >> l)-1:0] v;
         for (genvar j = 0; j < (LEAVES >> l); j++) begin : g_node
            if (l == 0) begin : g_leaf
               if (j < DEPTH) begin : g_used
                  assign v[j] = slot_eq[j];
               end else begin : g_pad
                  assign v[j] = 1'b0;
               end
            end else begin : g_or
               assign v[j] = g_lvl[l-1].v[2*j] | g_lvl[l-1].v[2*j+1];
            end
         end
      end
      assign hit = src_vld && g_lvl[LVL].v[0];
   end
endmodule

// File: rtl/dest_scoreboard.sv
module dest_scoreboard #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned REG_W = 5,
   parameter sb_pkg::match_style_e STYLE = sb_pkg::MATCH_FLAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_req,
   input  logic             ins_dst_vld,
   input  logic [REG_W-1:0] ins_dst_idx,
   output logic             ins_ack,
   input  logic             rem_req,
   input  logic             src_a_vld,
   input  logic [REG_W-1:0] src_a_idx,
   output logic             hit_a,
   input  logic             src_b_vld,
   input  logic [REG_W-1:0] src_b_idx,
   output logic             hit_b,
   input  logic             disp_req,
   output logic             stall,
   output logic             full,
   output logic             empty
);
   localparam int unsigned PTR_W = sb_pkg::ptr_width(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dest_scoreboard: DEPTH must be at least 2");
   end
   if (REG_W < 1) begin : g_bad_width
      $error("dest_scoreboard: REG_W must be at least 1");
   end

   logic             pop_ok;
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [DEPTH-1:0] occ;
   logic [DEPTH-1:0] tag_vld;
   logic [DEPTH*REG_W-1:0] tag_idx;
   logic [1:0]       src_vld;
   logic [2*REG_W-1:0] src_idx;
   logic [1:0]       port_hit;

   sb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (ins_req),
      .pop_req  (rem_req),
      .push_ok  (ins_ack),
      .pop_ok   (pop_ok),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .is_full  (full),
      .is_empty (empty)
   );

   sb_tag_store #(.DEPTH(DEPTH), .REG_W(REG_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ins_ack),
      .wr_ptr  (wr_ptr),
      .wr_vld  (ins_dst_vld),
      .wr_idx  (ins_dst_idx),
      .rd_en   (pop_ok),
      .rd_ptr  (rd_ptr),
      .occ     (occ),
      .tag_vld (tag_vld),
      .tag_idx (tag_idx)
   );

   assign src_vld = {src_b_vld, src_a_vld};
   assign src_idx = {src_b_idx, src_a_idx};

   for (genvar p = 0; p < 2; p++) begin : g_port
      sb_match_port #(.DEPTH(DEPTH), .REG_W(REG_W), .STYLE(STYLE)) u_match (
         .src_vld (src_vld[p]),
         .src_idx (src_idx[p*REG_W +: REG_W]),
         .occ     (occ),
         .tag_vld (tag_vld),
         .tag_idx (tag_idx),
         .hit     (port_hit[p])
      );
   end

   assign hit_a = port_hit[0];
   assign hit_b = port_hit[1];
   assign stall = disp_req && (hit_a || hit_b || full);
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned REG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ins_req,
   input logic             ins_dst_vld,
   input logic [REG_W-1:0] ins_dst_idx,
   input logic             ins_ack,
   input logic             rem_req,
   input logic             src_a_vld,
   input logic [REG_W-1:0] src_a_idx,
   input logic             hit_a,
   input logic             src_b_vld,
   input logic [REG_W-1:0] src_b_idx,
   input logic             hit_b,
   input logic             disp_req,
   input logic             stall,
   input logic             full,
   input logic             empty
);
   // R2
   new_tag_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_ack && ins_dst_vld) |=>
         ((src_a_vld && src_a_idx == $past(ins_dst_idx)) -> hit_a));

   // R3
   idle_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_a_vld |-> !hit_a);

   // R3
   idle_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_b_vld |-> !hit_b);

   // R6
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rem_req) |=> full);

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !ins_ack);

   // R7
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !ins_req) |=> (empty && !hit_a && !hit_b));

   // R10
   stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> disp_req);

   // R10
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_req && full) |-> stall);

   // R1
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
endmodule

bind dest_scoreboard sb_checker #(.DEPTH(DEPTH), .REG_W(REG_W)) u_sb_checker (.*);

// File: tb/test_dest_scoreboard.sv
module test_dest_scoreboard;
   localparam int DEPTH = 4;
   localparam int REG_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ins_req = 1'b0;
   logic             ins_dst_vld = 1'b0;
   logic [REG_W-1:0] ins_dst_idx = '0;
   logic             ins_ack;
   logic             rem_req = 1'b0;
   logic             src_a_vld = 1'b0;
   logic [REG_W-1:0] src_a_idx = '0;
   logic             hit_a;
   logic             src_b_vld = 1'b0;
   logic [REG_W-1:0] src_b_idx = '0;
   logic             hit_b;
   logic             disp_req = 1'b0;
   logic             stall;
   logic             full;
   logic             empty;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // Reference contents: bit REG_W = destination valid, low bits = index.
   logic [REG_W:0] model_q[$];

   always #5 clk = ~clk;

   dest_scoreboard #(.DEPTH(DEPTH), .REG_W(REG_W)) i_dest_scoreboard (
      .clk, .rst_n, .ins_req, .ins_dst_vld, .ins_dst_idx, .ins_ack,
      .rem_req, .src_a_vld, .src_a_idx, .hit_a, .src_b_vld, .src_b_idx,
      .hit_b, .disp_req, .stall, .full, .empty
   );

   function automatic bit model_hit(input logic v, input logic [REG_W-1:0] idx);
      if (!v) return 1'b0;
      foreach (model_q[k]) begin
         if (model_q[k][REG_W] && model_q[k][REG_W-1:0] == idx) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic check1(input string req, input string name, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, name, act, exp, $time);
      end
   endtask

   // Inputs are already driven; compare before the edge, then advance the model.
   task automatic cyc(input string req);
      bit e_a, e_b, e_full, e_empty, e_ack, e_stall, do_pop;
      #1;
      e_a     = model_hit(src_a_vld, src_a_idx);
      e_b     = model_hit(src_b_vld, src_b_idx);
      e_full  = (model_q.size() == DEPTH);
      e_empty = (model_q.size() == 0);
      e_ack   = ins_req && !e_full;
      e_stall = disp_req && (e_a || e_b || e_full);
      check1(req, "hit_a", hit_a, e_a);
      check1(req, "hit_b", hit_b, e_b);
      check1(req, "full", full, e_full);
      check1(req, "empty", empty, e_empty);
      check1(req, "ins_ack", ins_ack, e_ack);
      check1(req, "stall", stall, e_stall);
      do_pop = rem_req && !e_empty;
      @(posedge clk);
      if (do_pop) void'(model_q.pop_front());
      if (e_ack) model_q.push_back({ins_dst_vld, ins_dst_idx});
      @(negedge clk);
   endtask

   task automatic idle();
      ins_req = 0; ins_dst_vld = 0; ins_dst_idx = '0; rem_req = 0;
      src_a_vld = 0; src_a_idx = '0; src_b_vld = 0; src_b_idx = '0;
      disp_req = 0;
   endtask

   task automatic ins(input logic v, input int idx);
      ins_req = 1; ins_dst_vld = v; ins_dst_idx = REG_W'(idx);
   endtask

   task automatic look(input logic va, input int ia, input logic vb, input int ib);
      src_a_vld = va; src_a_idx = REG_W'(ia); src_b_vld = vb; src_b_idx = REG_W'(ib);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state, probing a few indices with valid sources
      look(1, 0, 1, 3); disp_req = 1; cyc("R1");
      idle();
      // R2: valid destination 3 becomes visible after the edge
      ins(1, 3); look(1, 3, 0, 0); cyc("R2");
      idle(); look(1, 3, 1, 3); cyc("R2");
      // R3: invalid source with matching index
      look(0, 3, 0, 3); cyc("R3");
      // R4: no-destination entry with index 0 occupies a slot
      ins(0, 0); cyc("R4");
      idle(); look(1, 0, 1, 0); cyc("R4");
      // R9: independent ports
      ins(1, 7); cyc("R9");
      idle(); look(1, 3, 1, 7); cyc("R9");
      look(1, 7, 1, 9); cyc("R9");
      look(1, 5, 1, 3); cyc("R9");
      // R6: fill the last slot, then a refused insert of 12
      idle(); ins(1, 9); cyc("R6");
      idle(); ins(1, 12); cyc("R6");
      idle(); look(1, 12, 1, 9); cyc("R6");
      // R10: stall from full alone, from hit, and gated by disp_req
      disp_req = 1; look(0, 0, 0, 0); cyc("R10");
      disp_req = 0; look(1, 3, 0, 0); cyc("R10");
      // R8: remove the oldest (3) while searching 3
      rem_req = 1; look(1, 3, 0, 0); disp_req = 1; cyc("R8");
      idle(); look(1, 3, 0, 0); disp_req = 1; cyc("R8");
      // R5: oldest-first removal, 7 and 9 stay visible until their turn
      idle(); rem_req = 1; look(1, 7, 1, 9); cyc("R5");
      idle(); look(1, 7, 1, 9); rem_req = 1; cyc("R5");
      idle(); look(1, 7, 1, 9); rem_req = 1; cyc("R5");
      idle(); look(1, 9, 1, 7); cyc("R5");
      // R11: insert and remove together keep occupancy
      ins(1, 4); cyc("R11");
      idle(); ins(1, 6); cyc("R11");
      idle(); ins(1, 8); rem_req = 1; look(1, 4, 1, 6); cyc("R11");
      idle(); look(1, 4, 1, 8); cyc("R11");
      idle(); rem_req = 1; cyc("R11");
      idle(); rem_req = 1; cyc("R11");
      // R7: remove on empty ignored; insert in same cycle still taken
      idle(); rem_req = 1; cyc("R7");
      idle(); rem_req = 1; ins(1, 2); look(1, 2, 0, 0); cyc("R7");
      idle(); look(1, 2, 0, 0); cyc("R7");
      idle(); rem_req = 1; cyc("R7");
      // R5: mixed random traffic on a small index range
      for (int n = 0; n < 400; n++) begin
         ins_req     = ($urandom_range(0, 2) != 0);
         ins_dst_vld = ($urandom_range(0, 3) != 0);
         ins_dst_idx = REG_W'($urandom_range(0, 7));
         rem_req     = ($urandom_range(0, 2) == 0);
         look($urandom_range(0, 1), $urandom_range(0, 7),
              $urandom_range(0, 1), $urandom_range(0, 7));
         disp_req    = $urandom_range(0, 1);
         cyc("R5");
      end
      idle();
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule